// File: doc/BRIEF.md
# SD Card SPI Command Frame Generator

This block assembles the six-byte command frame that an SD card expects in SPI mode and passes it, one byte at a time, to a byte-wide SPI transmitter. A controller supplies a 6-bit command index and a 32-bit argument and pulses a start request. The block computes the CRC7 checksum itself, so every command leaves with a correct checksum byte. No lookup table of precomputed trailers is needed for the commands that a card checks during power-up.

Bytes leave over a valid/ready handshake. A byte advances only when the transmitter accepts it. While no frame is in progress, the data port carries the all-ones filler byte and valid is low. A single-cycle done pulse marks the cycle after the last byte is accepted. Choosing commands, driving chip select and parsing responses belong to the surrounding controller.

Top module: `sd_cmd_framer`

## Requirements
- R1: Out of reset and whenever no frame is in progress, `busy_o`, `tx_valid_o` and `done_o` are 0 and `tx_data_o` is 0xFF.
- R2: A start request seen while idle is taken at that clock edge. From the next cycle `busy_o` and `tx_valid_o` are 1 and `tx_data_o` is the leading byte, which is 0x40 ORed with the command index (binary 01 in bits 7:6, index in bits 5:0).
- R3: Bytes 1 to 4 of the frame are the argument, most significant byte first.
- R4: Byte 5 is {crc7, 1}. The CRC7 uses polynomial x^7 + x^3 + 1, starts at zero, and runs most significant bit first over the 40 bits of bytes 0 to 4.
- R5: Index 0 with argument 0 ends in 0x95. Index 8 with argument 0x000001AA ends in 0x87.
- R6: A byte is transferred only in a cycle where `tx_valid_o` and `tx_ready_i` are both 1. While valid is high and ready is low, `tx_data_o` holds its value.
- R7: `done_o` is 1 for exactly the one cycle after the sixth byte is accepted. In that same cycle `busy_o` and `tx_valid_o` fall.
- R8: A start request while `busy_o` is 1 is ignored, and the frame in progress goes out unchanged.
- R9: `busy_o` stays 1 from the cycle after the start is taken until the done cycle, and each frame makes exactly six transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to send one frame; taken only while idle |
| cmd_idx_i | input | 6 | Command index, sampled with the start request |
| arg_i | input | 32 | Command argument, sampled with the start request |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse after the last byte is accepted |
| tx_data_o | output | 8 | Byte offered to the SPI transmitter; 0xFF when idle |
| tx_valid_o | output | 1 | Byte on `tx_data_o` is offered |
| tx_ready_i | input | 1 | Transmitter accepts the offered byte |

## Verification
A corrupted frame register shows up on `tx_data_o` at the very next accepted transfer as a wrong byte. A wrong checksum shows up only at the sixth transfer. A byte counter that is off by one makes `done_o` appear a cycle early or late, and the scoreboard then finds bytes missing from its queue or left over in it. A sequencing fault that lets a start through during a frame changes the following bytes at once. Throttled ready patterns show whether the offered byte moves without a handshake.

// File: rtl/sdf_pkg.sv
package sdf_pkg;

  localparam int SDF_BYTE_W = 8;
  localparam int SDF_IDX_W  = 6;
  localparam int SDF_ARG_W  = 32;
  localparam int SDF_CRC_W  = 7;
  localparam logic [SDF_CRC_W-1:0] SDF_CRC_POLY = 7'h09;  // x^7 + x^3 + 1
  localparam logic [SDF_BYTE_W-1:0] SDF_FILL = 8'hFF;

  typedef enum logic {
    SDF_IDLE = 1'b0,
    SDF_SEND = 1'b1
  } sdf_state_e;

  // One serial CRC7 step: shift in one message bit, MSB first.
  function automatic logic [SDF_CRC_W-1:0] sdf_crc_step(
      input logic [SDF_CRC_W-1:0] crc,
      input logic                 msg_bit);
    logic fb;
    fb = crc[SDF_CRC_W-1] ^ msg_bit;
    return {crc[SDF_CRC_W-2:0], 1'b0} ^ (fb ? SDF_CRC_POLY : '0);
  endfunction

endpackage

// File: rtl/sdf_crc_chain.sv
module sdf_crc_chain
  import sdf_pkg::*;
#(
  parameter int DATA_W = 40
) (
  input  logic [DATA_W-1:0]    data_i,
  output logic [SDF_CRC_W-1:0] crc_o
);

  logic [SDF_CRC_W-1:0] stage [DATA_W+1];

  assign stage[0] = '0;

  for (genvar i = 0; i < DATA_W; i++) begin : g_step
    assign stage[i+1] = sdf_crc_step(stage[i], data_i[DATA_W-1-i]);
  end

  assign crc_o = stage[DATA_W];

endmodule

// File: rtl/sdf_frame_shreg.sv
module sdf_frame_shreg #(
  parameter int          BYTE_W      = 8,
  parameter int          FRAME_BYTES = 6,
  parameter logic [BYTE_W-1:0] FILL  = 8'hFF
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load_i,
  input  logic                          shift_i,
  input  logic [BYTE_W*FRAME_BYTES-1:0] frame_i,
  output logic [BYTE_W-1:0]             head_o
);

  localparam int FRAME_W = BYTE_W * FRAME_BYTES;

  logic [FRAME_W-1:0] frame_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= {FRAME_BYTES{FILL}};
    end else if (load_i) begin
      frame_q <= frame_i;
    end else if (shift_i) begin
      frame_q <= {frame_q[FRAME_W-BYTE_W-1:0], FILL};
    end
  end

  assign head_o = frame_q[FRAME_W-1 -: BYTE_W];

endmodule

// File: rtl/sdf_seq_ctrl.sv
module sdf_seq_ctrl
  import sdf_pkg::*;
#(
  parameter int FRAME_BYTES = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic tx_ready_i,
  output logic accept_o,
  output logic fire_o,
  output logic last_fire_o,
  output logic busy_o,
  output logic done_o
);

  localparam int CNT_W = $clog2(FRAME_BYTES);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_BYTES - 1);

  sdf_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;

  assign busy_o      = (state_q == SDF_SEND);
  assign accept_o    = (state_q == SDF_IDLE) && start_i;
  assign fire_o      = busy_o && tx_ready_i;
  assign last_fire_o = fire_o && (cnt_q == LAST_IDX);
  assign done_o      = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SDF_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= last_fire_o;
      if (accept_o) begin
        state_q <= SDF_SEND;
        cnt_q   <= '0;
      end else if (last_fire_o) begin
        state_q <= SDF_IDLE;
        cnt_q   <= '0;
      end else if (fire_o) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/sd_cmd_framer.sv
module sd_cmd_framer
  import sdf_pkg::*;
#(
  parameter int BYTE_W = SDF_BYTE_W,
  parameter int IDX_W  = SDF_IDX_W,
  parameter int ARG_W  = SDF_ARG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [IDX_W-1:0]  cmd_idx_i,
  input  logic [ARG_W-1:0]  arg_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [BYTE_W-1:0] tx_data_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i
);

  localparam int HDR_W       = BYTE_W + ARG_W;
  localparam int FRAME_W     = HDR_W + BYTE_W;
  localparam int FRAME_BYTES = FRAME_W / BYTE_W;
  localparam int TAG_W       = BYTE_W - IDX_W;
  localparam logic [TAG_W-1:0] TAG = TAG_W'(1);  // binary 01 above the index

  // Named internal events, visible to the bound checker.
  logic accept_w;
  logic fire_w;
  logic last_fire_w;

  logic [BYTE_W-1:0]    lead_byte;
  logic [HDR_W-1:0]     header;
  logic [SDF_CRC_W-1:0] crc;
  logic [FRAME_W-1:0]   frame;

  assign lead_byte = {TAG, cmd_idx_i};
  assign header    = {lead_byte, arg_i};
  assign frame     = {header, crc, 1'b1};

  sdf_crc_chain #(
    .DATA_W (HDR_W)
  ) u_crc (
    .data_i (header),
    .crc_o  (crc)
  );

  sdf_seq_ctrl #(
    .FRAME_BYTES (FRAME_BYTES)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .tx_ready_i  (tx_ready_i),
    .accept_o    (accept_w),
    .fire_o      (fire_w),
    .last_fire_o (last_fire_w),
    .busy_o      (busy_o),
    .done_o      (done_o)
  );

  sdf_frame_shreg #(
    .BYTE_W      (BYTE_W),
    .FRAME_BYTES (FRAME_BYTES),
    .FILL        (SDF_FILL)
  ) u_shreg (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (accept_w),
    .shift_i (fire_w),
    .frame_i (frame),
    .head_o  (tx_data_o)
  );

  assign tx_valid_o = busy_o;

endmodule

// File: rtl/sdf_checker.sv
module sdf_checker #(
  parameter int BYTE_W = 8,
  parameter int IDX_W  = 6,
  parameter int ARG_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [IDX_W-1:0]  cmd_idx_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [BYTE_W-1:0] tx_data_o,
  input logic              tx_valid_o,
  input logic              tx_ready_i,
  input logic              accept_w,
  input logic              fire_w,
  input logic              last_fire_w
);

  localparam int FRAME_BYTES = (2 * BYTE_W + ARG_W) / BYTE_W;
  localparam int FC_W        = $clog2(FRAME_BYTES + 1);

  logic [FC_W-1:0] fires_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        fires_seen <= '0;
    else if (accept_w) fires_seen <= '0;
    else if (fire_w)   fires_seen <= fires_seen + 1'b1;
  end

  assert_idle_filler_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (tx_data_o == 8'hFF) && !tx_valid_o);

  assert_lead_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |=> busy_o && tx_valid_o && tx_data_o[BYTE_W-1 -: 2] == 2'b01
                 && tx_data_o[IDX_W-1:0] == $past(cmd_idx_i));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o));

  assert_done_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    last_fire_w |=> done_o && !busy_o);

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && start_i && !fire_w |=> busy_o && $stable(tx_data_o));

  assert_busy_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && !last_fire_w |=> busy_o);

  assert_six_fires_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> fires_seen == FC_W'(FRAME_BYTES));

endmodule

bind sd_cmd_framer sdf_checker #(
  .BYTE_W (BYTE_W),
  .IDX_W  (IDX_W),
  .ARG_W  (ARG_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .cmd_idx_i   (cmd_idx_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .tx_data_o   (tx_data_o),
  .tx_valid_o  (tx_valid_o),
  .tx_ready_i  (tx_ready_i),
  .accept_w    (accept_w),
  .fire_w      (fire_w),
  .last_fire_w (last_fire_w)
);

// File: tb/sd_cmd_framer_tb.sv
`timescale 1ns/1ps
module sd_cmd_framer_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [5:0]  cmd_idx_i = '0;
  logic [31:0] arg_i = '0;
  logic        busy_o, done_o, tx_valid_o;
  logic [7:0]  tx_data_o;
  logic        tx_ready_i = 1'b1;

  int checks = 0;
  int fails  = 0;
  int ready_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [7:0]  exp_q[$];
  logic [7:0]  last_byte = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  sd_cmd_framer u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmd_idx_i(cmd_idx_i),
    .arg_i(arg_i), .busy_o(busy_o), .done_o(done_o), .tx_data_o(tx_data_o),
    .tx_valid_o(tx_valid_o), .tx_ready_i(tx_ready_i)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // CRC7 as polynomial long division of message * x^7 by 0x89.
  function automatic logic [6:0] ref_crc(input logic [39:0] msg);
    logic [46:0] rem;
    rem = {msg, 7'b0};
    for (int i = 46; i >= 7; i--)
      if (rem[i]) rem = rem ^ (47'h89 << (i - 7));
    return rem[6:0];
  endfunction

  // Ready pattern from the sink, changed only at the falling edge.
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (ready_mode)
      0:       tx_ready_i = 1'b1;
      1:       tx_ready_i = lfsr[0];
      default: tx_ready_i = (lfsr[1:0] == 2'b00);
    endcase
  end

  // Monitor: pops the scoreboard on every accepted byte (R3, R4, R6).
  always @(negedge clk) begin
    #2;
    if (rst_n && tx_valid_o && tx_ready_i) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9 unexpected transfer", {24'h0, tx_data_o}, 32'h0);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        check(tx_data_o == e, "R3/R4 frame byte", {24'h0, tx_data_o}, {24'h0, e});
      end
      last_byte = tx_data_o;
    end
  end

  task automatic send_frame(input logic [5:0] idx, input logic [31:0] arg,
                            input bit poke);
    logic [39:0] hdr;
    int cyc;
    hdr = {2'b01, idx, arg};
    exp_q.push_back(hdr[39:32]);
    for (int b = 3; b >= 0; b--) exp_q.push_back(arg[b*8 +: 8]);
    exp_q.push_back({ref_crc(hdr), 1'b1});
    @(negedge clk);
    cmd_idx_i = idx; arg_i = arg; start_i = 1'b1;
    #2;
    check(done_o == 1'b0, "R7 done low after pulse", {31'h0, done_o}, 32'h0);
    check(busy_o == 1'b0, "R1 idle before start", {31'h0, busy_o}, 32'h0);
    @(negedge clk);
    start_i = 1'b0;
    cmd_idx_i = ~idx; arg_i = ~arg;   // inputs no longer sampled
    #2;
    check(busy_o && tx_valid_o && tx_data_o == {2'b01, idx},
          "R2 lead byte", {23'h0, busy_o, tx_data_o}, {24'h1, 2'b01, idx});
    cyc = 0;
    forever begin
      @(negedge clk);
      if (poke && (cyc % 3 == 1)) begin start_i = 1'b1; cmd_idx_i = 6'h3F; end
      else start_i = 1'b0;
      #2;
      if (done_o) break;
      cyc++;
      if (!busy_o || cyc > 400) begin
        check(1'b0, "R9 busy held until done", {31'h0, busy_o}, 32'h1);
        break;
      end
    end
    start_i = 1'b0;
    check(exp_q.size() == 0, "R9 six transfers", exp_q.size(), 0);
    check(!busy_o && !tx_valid_o && tx_data_o == 8'hFF, "R1 filler after frame",
          {22'h0, busy_o, tx_valid_o, tx_data_o}, 32'hFF);
    exp_q.delete();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    check(!busy_o && !done_o && !tx_valid_o && tx_data_o == 8'hFF, "R1 reset state",
          {21'h0, busy_o, done_o, tx_valid_o, tx_data_o}, 32'hFF);
    @(negedge clk);
    rst_n = 1'b1;

    ready_mode = 0;
    send_frame(6'd0, 32'h0000_0000, 1'b0);
    check(last_byte == 8'h95, "R5 CMD0 trailer", {24'h0, last_byte}, 32'h95);

    ready_mode = 1;
    send_frame(6'd8, 32'h0000_01AA, 1'b0);
    check(last_byte == 8'h87, "R5 CMD8 trailer", {24'h0, last_byte}, 32'h87);

    send_frame(6'd55, 32'h0000_0000, 1'b0);
    ready_mode = 2;   // sparse ready exercises R6
    send_frame(6'd41, 32'h4000_0000, 1'b0);

    ready_mode = 1;   // start pokes during the frame: R8
    send_frame(6'd17, 32'hDEAD_BEEF, 1'b1);
    ready_mode = 0;
    send_frame(6'd24, 32'h0123_4567, 1'b1);

    repeat (2) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule